// File: doc/BRIEF.md
# DRAM Cycle Mode Decoder

This block is a clocked model of the control logic that sits on the device side of an asynchronous DRAM with two byte lanes. It samples the row strobe, the two column strobes (one per byte lane), the write enable and the output enable on a fast system clock. From these it classifies every row cycle into an operation mode. It also keeps the internal refresh row counter and decides, lane by lane, when a byte is written and when the data pins are driven. The memory array, the analog timing and the self-refresh oscillator sit outside the block. The array consumes the per-lane write strobes and the drive enables. The refresh engine consumes the refresh row together with its valid pulse.

All strobe inputs are active low. They pass through one register stage, and edges are found by comparing that stage with the one after it. Every output is registered, so an output reacts two clock edges after the pin change that causes it. The two column strobes are merged by OR into one combined strobe. The merged strobe falls with the earlier lane and rises with the later lane, and it alone decides the mode. Writes and output drive are still decided separately for each lane, from that lane's own strobe. The refresh output is a plain valid pulse with no ready: refresh can't be stalled, so there is no back-pressure path.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset, `mode` is idle (code 0), `drive_en` and `wr_strobe` are 0, `rfsh_valid` is 0, and the refresh counter starts at row 0.
- R2: If at least one column strobe is already low in the sample where the row strobe falls, the cycle is a CAS-before-RAS refresh (code 6). This holds even when only one lane is low. Once, at the start of the cycle, `rfsh_row` reports the counter value with a one-cycle `rfsh_valid`, and the counter then advances modulo 2^ROW_W.
- R3: A row cycle in which both column strobes stay high is a RAS-only refresh (code 5). When the row strobe rises, one `rfsh_valid` pulse reports the address that was sampled when the row strobe fell. No lane drives during the cycle.
- R4: If write enable is low when the combined column strobe falls, the cycle is an early write (code 2). Each lane whose strobe falls gets exactly one `wr_strobe` pulse, and `drive_en` stays 0.
- R5: If the combined column strobe falls with write enable high, `mode` is read (code 1). A later fall of write enable while the combined strobe is low turns the cycle into read-modify-write (code 4) when output enable was low at some point since that column fall. Otherwise it becomes a delayed write (code 3). Each lane whose strobe is low gets one `wr_strobe` pulse.
- R6: A lane whose column strobe stays high is never written and never driven, whatever the other lane does. `wr_strobe[0]`/`drive_en[0]` belong to the lower lane (`lcas_n`), and bit 1 belongs to the upper lane (`ucas_n`).
- R7: A lane starts driving during an access when its strobe is low, write enable is high and output enable is low. Once driving, it keeps driving after its column strobe rises. It stops only when the row strobe and its column strobe are both high, when output enable is high, or when write enable is low.
- R8: If a CAS-before-RAS cycle keeps the row strobe low for SREF_CYCLES clocks, `mode` becomes self-refresh (code 7). After that, every TICK_CYCLES clocks a `rfsh_valid` pulse reports the counter, which then advances.
- R9: One clock after the rising edge of the row strobe is detected, `mode` returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| ucas_n | input | 1 | Upper-lane column strobe, active low |
| lcas_n | input | 1 | Lower-lane column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ROW_W | Multiplexed address pins |
| mode | output | 3 | Current cycle mode code |
| wr_strobe | output | 2 | One-cycle write pulse per lane |
| drive_en | output | 2 | Per-lane data drive enable |
| rfsh_valid | output | 1 | Pulse: `rfsh_row` holds a row being refreshed |
| rfsh_row | output | ROW_W | Row refreshed by this pulse |

## Verification
The bench aims at the single-lane refresh case. A decoder that ANDs the two column strobes instead of ORing them would call such a cycle RAS-only and report the address pins instead of the counter. It holds data on the pins after a column strobe rises, which catches a design that drops drive on the strobe instead of on the row-and-column-high condition. It separates delayed write from read-modify-write purely by whether output enable was seen low, and it holds the row strobe low long enough to enter self-refresh and count the tick pulses. A run of more than 512 refresh cycles checks that the row counter wraps rather than saturating or skipping.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;
  typedef enum logic [2:0] {
    MD_IDLE = 3'd0,
    MD_READ = 3'd1,
    MD_EWR  = 3'd2,
    MD_DWR  = 3'd3,
    MD_RMW  = 3'd4,
    MD_ROR  = 3'd5,
    MD_CBR  = 3'd6,
    MD_SELF = 3'd7
  } mode_e;
endpackage

// File: rtl/dram_pin_sync.sv
module dram_pin_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  output logic [W-1:0] cur,
  output logic [W-1:0] prv
);
  // strobes are active low, so the idle value is all ones
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= '1;
      prv <= '1;
    end else begin
      cur <= pins;
      prv <= cur;
    end
  end
endmodule

// File: rtl/dram_lane_ctl.sv
module dram_lane_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_now,
  input  logic ew_block,
  input  logic ras_n,
  input  logic cas_n,
  input  logic cas_n_prv,
  input  logic we_n,
  input  logic we_fall,
  input  logic oe_n,
  output logic wr,
  output logic drv
);
  logic cas_fall, on_c, off_c;

  assign cas_fall = cas_n_prv & ~cas_n;
  assign on_c  = acc_now & ~cas_n & we_n & ~oe_n & ~ew_block;
  assign off_c = (ras_n & cas_n) | oe_n | ~we_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr  <= 1'b0;
      drv <= 1'b0;
    end else begin
      wr <= acc_now & ((cas_fall & ~we_n) | (we_fall & ~cas_n));
      if (off_c)     drv <= 1'b0;
      else if (on_c) drv <= 1'b1;
    end
  end

  AST_STROBE_NEEDS_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> !$past(cas_n)); // R6
  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && drv)); // R7
endmodule

// File: rtl/dram_rfsh_ctr.sv
module dram_rfsh_ctr #(
  parameter int ROW_W       = 9,
  parameter int SREF_CYCLES = 10000,
  parameter int TICK_CYCLES = 1560
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cbr_start,
  input  logic             cbr_hold,
  output logic [ROW_W-1:0] row_cnt,
  output logic             self_on,
  output logic             tick
);
  localparam int TMAX = (SREF_CYCLES > TICK_CYCLES) ? SREF_CYCLES : TICK_CYCLES;
  localparam int TW   = $clog2(TMAX + 1);

  logic [TW-1:0] timer;
  logic          bump;

  assign tick = self_on & cbr_hold & (timer == TW'(TICK_CYCLES - 1));
  assign bump = cbr_start | tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer   <= '0;
      self_on <= 1'b0;
      row_cnt <= '0;
    end else begin
      if (cbr_start || !cbr_hold) begin
        timer   <= '0;
        self_on <= 1'b0;
      end else if (!self_on) begin
        if (timer == TW'(SREF_CYCLES - 1)) begin
          self_on <= 1'b1;
          timer   <= '0;
        end else begin
          timer <= timer + 1'b1;
        end
      end else begin
        timer <= (timer == TW'(TICK_CYCLES - 1)) ? '0 : timer + 1'b1;
      end
      if (bump) row_cnt <= row_cnt + 1'b1;
    end
  end

  AST_COUNTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    bump |=> row_cnt == $past(row_cnt) + 1'b1); // R2
  AST_COUNTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bump |=> $stable(row_cnt)); // R2
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
  import dram_dec_pkg::*;
#(
  parameter int ROW_W       = 9,
  parameter int SREF_CYCLES = 10000,
  parameter int TICK_CYCLES = 1560
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             ucas_n,
  input  logic             lcas_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [ROW_W-1:0] addr,
  output logic [2:0]       mode,
  output logic [1:0]       wr_strobe,
  output logic [1:0]       drive_en,
  output logic             rfsh_valid,
  output logic [ROW_W-1:0] rfsh_row
);
  localparam int LANES = 2;

  logic [3:0]       cur, prv;
  logic             s_ras, s_ucas, s_lcas, s_we;
  logic             p_ras, p_ucas, p_lcas, p_we;
  logic             s_oe;
  logic [ROW_W-1:0] s_addr, row_q;
  logic             ras_fall, ras_rise, cas_lo, cas_lo_p, cas_fall, we_fall;
  logic             acc_now, cbr_start, cbr_hold, oe_seen;
  logic [ROW_W-1:0] row_cnt;
  logic             self_on, tick;
  mode_e            md;
  logic [LANES-1:0] lane_cur, lane_prv;

  dram_pin_sync #(.W(4)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .pins({ras_n, ucas_n, lcas_n, we_n}),
    .cur(cur), .prv(prv)
  );

  assign {s_ras, s_ucas, s_lcas, s_we} = cur;
  assign {p_ras, p_ucas, p_lcas, p_we} = prv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_oe   <= 1'b1;
      s_addr <= '0;
    end else begin
      s_oe   <= oe_n;
      s_addr <= addr;
    end
  end

  // combined column strobe: low while either lane is low
  assign cas_lo    = ~s_ucas | ~s_lcas;
  assign cas_lo_p  = ~p_ucas | ~p_lcas;
  assign cas_fall  = cas_lo & ~cas_lo_p;
  assign ras_fall  = p_ras & ~s_ras;
  assign ras_rise  = ~p_ras & s_ras;
  assign we_fall   = p_we & ~s_we;
  assign cbr_start = ras_fall & cas_lo;
  assign cbr_hold  = ~s_ras & ((md == MD_CBR) | (md == MD_SELF));
  assign acc_now   = ~s_ras & ((md == MD_ROR) | (md == MD_READ) | (md == MD_EWR) |
                               (md == MD_DWR) | (md == MD_RMW));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      md      <= MD_IDLE;
      row_q   <= '0;
      oe_seen <= 1'b0;
    end else if (ras_rise) begin
      md <= MD_IDLE;
    end else if (ras_fall) begin
      md    <= cas_lo ? MD_CBR : MD_ROR;
      row_q <= s_addr;
    end else if (!s_ras) begin
      if (md == MD_CBR && self_on) begin
        md <= MD_SELF;
      end else if (acc_now) begin
        if (cas_fall) begin
          md      <= s_we ? MD_READ : MD_EWR;
          oe_seen <= ~s_oe;
        end else begin
          if (md == MD_READ && we_fall && cas_lo)
            md <= oe_seen ? MD_RMW : MD_DWR;
          if (cas_lo && !s_oe) oe_seen <= 1'b1;
        end
      end
    end
  end

  assign mode = md;

  dram_rfsh_ctr #(
    .ROW_W(ROW_W), .SREF_CYCLES(SREF_CYCLES), .TICK_CYCLES(TICK_CYCLES)
  ) u_rfsh (
    .clk(clk), .rst_n(rst_n),
    .cbr_start(cbr_start), .cbr_hold(cbr_hold),
    .row_cnt(row_cnt), .self_on(self_on), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rfsh_valid <= 1'b0;
      rfsh_row   <= '0;
    end else begin
      rfsh_valid <= cbr_start | tick | (ras_rise & (md == MD_ROR));
      if (ras_rise && md == MD_ROR) rfsh_row <= row_q;
      else if (cbr_start || tick)   rfsh_row <= row_cnt;
    end
  end

  assign lane_cur = {s_ucas, s_lcas};
  assign lane_prv = {p_ucas, p_lcas};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    dram_lane_ctl u_lane (
      .clk(clk), .rst_n(rst_n),
      .acc_now(acc_now), .ew_block(md == MD_EWR),
      .ras_n(s_ras), .cas_n(lane_cur[i]), .cas_n_prv(lane_prv[i]),
      .we_n(s_we), .we_fall(we_fall), .oe_n(s_oe),
      .wr(wr_strobe[i]), .drv(drive_en[i])
    );
  end

  AST_EWRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_EWR) |-> (drive_en == 2'b00)); // R4
  AST_RASONLY_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_ROR) |-> (drive_en == 2'b00)); // R3
  AST_IDLE_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ras_rise |=> (mode == MD_IDLE)); // R9
  AST_SELF_FROM_CBR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode == MD_SELF) |-> ($past(mode) == MD_CBR)); // R8
endmodule

// File: tb/sim_dram_cycle_decoder.sv
module sim_dram_cycle_decoder;
  localparam int ROW_W = 9;
  localparam int SREF  = 10000;
  localparam int TICK  = 1560;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1, ucas_n = 1, lcas_n = 1, we_n = 1, oe_n = 1;
  logic [ROW_W-1:0] addr = '0;
  logic [2:0] mode;
  logic [1:0] wr_strobe, drive_en;
  logic rfsh_valid;
  logic [ROW_W-1:0] rfsh_row;

  int checks = 0, errors = 0;
  int wr0 = 0, wr1 = 0, rf_n = 0;
  logic [ROW_W-1:0] last_row = '0;
  int exp_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dram_cycle_decoder u0 (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .mode(mode), .wr_strobe(wr_strobe),
    .drive_en(drive_en), .rfsh_valid(rfsh_valid), .rfsh_row(rfsh_row)
  );

  always @(negedge clk) if (rst_n) begin
    if (wr_strobe[0]) wr0++;
    if (wr_strobe[1]) wr1++;
    if (rfsh_valid) begin rf_n++; last_row = rfsh_row; end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pins(logic r, logic u, logic l, logic w, logic o);
    ras_n = r; ucas_n = u; lcas_n = l; we_n = w; oe_n = o;
    step(3);
  endtask

  // kinds: 0 read, 1 early write, 2 delayed write, 3 rmw, 4 ras-only, 5 cbr
  function automatic int exp_mode(int kind);
    case (kind)
      0: return 1;
      1: return 2;
      2: return 3;
      3: return 4;
      4: return 5;
      default: return 6;
    endcase
  endfunction

  function automatic int exp_writes(int kind, logic [1:0] m, int lane);
    if (kind >= 1 && kind <= 3) return int'(m[lane]);
    return 0;
  endfunction

  task automatic run_cycle(int kind, logic [1:0] m, logic [ROW_W-1:0] a);
    int w0, w1, r0;
    logic u, l;
    w0 = wr0; w1 = wr1; r0 = rf_n;
    u = ~m[1]; l = ~m[0];
    addr = a;
    case (kind)
      0: begin
        pins(0, 1, 1, 1, 1);
        pins(0, u, l, 1, 0);
        check("R5 read mode", mode, exp_mode(kind));
        check("R7 read drive", drive_en, m);
        check("R6 idle lane no drive", drive_en & ~m, 0);
      end
      1: begin
        pins(1, 1, 1, 0, 1);
        pins(0, 1, 1, 0, 1);
        pins(0, u, l, 0, 0);
        check("R4 early write mode", mode, exp_mode(kind));
        check("R4 early write no drive", drive_en, 0);
      end
      2: begin
        pins(0, 1, 1, 1, 1);
        pins(0, u, l, 1, 1);
        check("R5 provisional read", mode, 1);
        pins(0, u, l, 0, 1);
        check("R5 delayed write mode", mode, exp_mode(kind));
      end
      3: begin
        pins(0, 1, 1, 1, 1);
        pins(0, u, l, 1, 0);
        check("R7 rmw read drive", drive_en, m);
        pins(0, u, l, 1, 1);
        check("R7 oe high stops drive", drive_en, 0);
        pins(0, u, l, 0, 1);
        check("R5 rmw mode", mode, exp_mode(kind));
      end
      4: begin
        pins(0, 1, 1, 1, 1);
        check("R3 ras-only mode", mode, exp_mode(kind));
        check("R3 ras-only no drive", drive_en, 0);
      end
      default: begin
        pins(1, u, l, 1, 1);
        pins(0, u, l, 1, 1);
        check("R2 cbr mode", mode, exp_mode(kind));
        check("R2 cbr row", last_row, exp_cnt);
        check("R2 cbr one pulse", rf_n - r0, 1);
        exp_cnt = (exp_cnt + 1) % 512;
      end
    endcase
    pins(1, u, l, 1, 1);
    pins(1, 1, 1, 1, 1);
    check("R9 idle after cycle", mode, 0);
    check("R7 drive off at end", drive_en, 0);
    check("R4 R5 R6 lane0 writes", wr0 - w0, exp_writes(kind, m, 0));
    check("R4 R5 R6 lane1 writes", wr1 - w1, exp_writes(kind, m, 1));
    if (kind == 4) begin
      check("R3 ras-only pulse", rf_n - r0, 1);
      check("R3 ras-only row", last_row, a);
    end else if (kind != 5) begin
      check("R3 no refresh on access", rf_n - r0, 0);
    end
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int r0;
    void'($urandom(32'd1234));
    step(3);
    rst_n = 1;
    step(2);
    check("R1 reset mode", mode, 0);
    check("R1 reset drive", drive_en, 0);
    check("R1 reset strobe", wr_strobe, 0);
    check("R1 reset refresh", rfsh_valid, 0);

    // single upper lane low before row strobe: still CBR refresh with counter row 0
    run_cycle(5, 2'b10, 9'h1AA);
    check("R2 single lane counter start", last_row, 0);

    // EDO hold: drive survives column rise, dropped by row+column high
    addr = 9'h055;
    pins(0, 1, 1, 1, 1);
    pins(0, 0, 0, 1, 0);
    pins(0, 1, 1, 1, 0);
    check("R7 drive held after cas rise", drive_en, 3);
    pins(0, 0, 1, 1, 0);
    pins(1, 0, 1, 1, 0);
    check("R7 lower off when ras and cas high", drive_en, 2);
    pins(1, 1, 1, 1, 0);
    check("R7 upper off when ras and cas high", drive_en, 0);
    pins(1, 1, 1, 1, 1);
    // WE low turns the drive off
    pins(0, 1, 1, 1, 1);
    pins(0, 1, 0, 1, 0);
    check("R6 lower-only read drive", drive_en, 1);
    pins(0, 1, 0, 0, 0);
    check("R7 we low stops drive", drive_en, 0);
    pins(1, 1, 1, 1, 1);

    // random mix
    for (int i = 0; i < 60; i++) begin
      int kind;
      logic [1:0] m;
      kind = int'($urandom_range(0, 5));
      m = 2'($urandom_range(1, 3));
      run_cycle(kind, m, 9'($urandom));
    end

    // counter wraps past 511
    while (exp_cnt != 510) run_cycle(5, 2'b11, 9'h000);
    run_cycle(5, 2'b01, 9'h000);
    check("R2 row 510", last_row, 510);
    run_cycle(5, 2'b11, 9'h000);
    check("R2 row 511", last_row, 511);
    run_cycle(5, 2'b11, 9'h000);
    check("R2 wrap to 0", last_row, 0);

    // self refresh
    r0 = rf_n;
    pins(1, 0, 0, 1, 1);
    pins(0, 0, 0, 1, 1);
    step(100);
    check("R8 cbr before limit", mode, 6);
    step(SREF + TICK / 2);
    check("R8 self refresh entered", mode, 7);
    step(3 * TICK);
    check("R8 tick count", rf_n - r0, 4);
    check("R8 last tick row", last_row, (exp_cnt + 3) % 512);
    exp_cnt = (exp_cnt + 4) % 512;
    pins(1, 0, 0, 1, 1);
    check("R9 exit self refresh", mode, 0);
    pins(1, 1, 1, 1, 1);
    run_cycle(5, 2'b11, 9'h000);
    check("R8 counter after self", last_row, (exp_cnt + 511) % 512);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule